// File: doc/BRIEF.md
# Serial Register Loader with Double-Buffered Commit

This block receives configuration words for a frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. All three wires are asynchronous to the system clock, so each passes through a two-stage synchronizer. Edges of the synchronized serial clock and load strobe are then detected in the system clock domain. Each rising serial clock shifts one data bit into a 32-bit word, with the most significant bit arriving first. When the load strobe rises, the three lowest bits of the word pick one of five destination registers.

Two of the destinations hold settings that must change together: phase, modulus, reference counter, reference doubler, reference halver and current setting. A write to either of these registers only fills a staging copy. The settings take effect only when register 0 is written next. That write also loads the integer and fractional divider values directly. Registers 3 and 4 are loaded straight to their outputs. A one-cycle pulse marks every system clock in which any active output may change.

Top module: `serial_cfg_loader`

## Requirements
- R1: A rising edge of the synchronized serial clock shifts the synchronized data bit into the low end of a 32-bit word. The first bit sent therefore ends up in bit 31.
- R2: A rising load strobe routes the word by its bits 2:0. Code 000 selects register 0, 001 selects register 1, 010 register 2, 011 register 3 and 100 register 4.
- R3: A load strobe with bits 2:0 equal to 101, 110 or 111 changes no output and produces no update pulse.
- R4: Writes to register 1 or register 2 only fill the staging copy. No active output changes on such a write.
- R5: A write to register 0 loads the integer value from bits 26:15 and the fractional value from bits 14:3. In the same clock it makes every staged value active.
- R6: Register 1 holds the phase in bits 14:3. Register 2 holds the doubler flag in bit 25, the halver flag in bit 24, the reference counter in bits 23:19, the current setting in bits 18:15 and the modulus in bits 14:3.
- R7: Registers 3 and 4 present word bits 31:3 directly as 29-bit outputs when written.
- R8: While reset is asserted, every staging register and every output is zero.
- R9: The update output is high for exactly one system clock after each write to register 0, 3 or 4, and never otherwise.
- R10: Outputs change on the third rising system clock edge after the load strobe pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_ld_i | input | 1 | Load strobe, acts on its rising edge |
| n_int_o | output | 12 | Active integer divider value |
| frac_o | output | 12 | Active fractional value |
| mod_o | output | 12 | Active modulus |
| phase_o | output | 12 | Active phase |
| rdiv_o | output | 5 | Active reference counter |
| icp_o | output | 4 | Active current setting |
| dbl_o | output | 1 | Active reference doubler flag |
| half_o | output | 1 | Active reference halver flag |
| cfg3_o | output | 29 | Register 3 contents |
| cfg4_o | output | 29 | Register 4 contents |
| upd_o | output | 1 | One-cycle pulse when active outputs are loaded |

## Verification
Suppose the staging copy goes wrong, for example a field is stored in the wrong place or a write leaks straight through. This stays hidden until the next register 0 write, so every check has to follow a staged write with a commit. A leak, by contrast, shows up three clocks after the staging strobe as an active output that moves with no update pulse. A wrong shift position or a wrong decode shows up as a wrong field value in the same cycle as the commit. The reference model is compared on every clock, so a latency that is off by one shows up at once as a mismatch on the update pulse.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 3;
  localparam int NREG   = 5;
  localparam int NUM_W  = 12;
  localparam int RDIV_W = 5;
  localparam int ICP_W  = 4;
  localparam int RAW_W  = WORD_W - SEL_W;

  localparam int LO_FLD  = SEL_W;
  localparam int N_LSB   = LO_FLD + NUM_W;
  localparam int ICP_LSB = N_LSB;
  localparam int R_LSB   = ICP_LSB + ICP_W;
  localparam int HALF_B  = R_LSB + RDIV_W;
  localparam int DBL_B   = HALF_B + 1;

  typedef struct packed {
    logic              dbl;
    logic              half;
    logic [RDIV_W-1:0] rdiv;
    logic [ICP_W-1:0]  icp;
    logic [NUM_W-1:0]  modv;
    logic [NUM_W-1:0]  phase;
  } dbuf_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= async_i[g];
        s2_q <= s1_q;
      end
    end
    assign sync_o[g] = s2_q;
  end
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift
  import cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              sld_i,
  output logic [WORD_W-1:0] word_o,
  output logic              ld_rise_o
);
  logic              sclk_prev_q, sld_prev_q;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              clk_rise;

  assign clk_rise  = sclk_i & ~sclk_prev_q;
  assign ld_rise_o = sld_i & ~sld_prev_q;

  always_comb begin
    sr_d = sr_q;
    if (clk_rise) sr_d = {sr_q[WORD_W-2:0], sdat_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b0;
      sld_prev_q  <= 1'b0;
      sr_q        <= '0;
    end else begin
      sclk_prev_q <= sclk_i;
      sld_prev_q  <= sld_i;
      if (clk_rise) sr_q <= sr_d;
    end
  end

  assign word_o = sr_q;
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [WORD_W-1:0] word_i,
  output dbuf_t             act_o,
  output logic [NUM_W-1:0]  n_o,
  output logic [NUM_W-1:0]  frac_o,
  output logic [RAW_W-1:0]  cfg3_o,
  output logic [RAW_W-1:0]  cfg4_o,
  output logic              upd_o
);
  dbuf_t             stg_q, stg_d, act_q, act_d;
  logic [NUM_W-1:0]  n_q, n_d, frac_q, frac_d;
  logic [RAW_W-1:0]  c3_q, c3_d, c4_q, c4_d;
  logic              upd_q, upd_d;
  logic [SEL_W-1:0]  sel;

  assign sel = word_i[SEL_W-1:0];

  always_comb begin
    stg_d  = stg_q;
    act_d  = act_q;
    n_d    = n_q;
    frac_d = frac_q;
    c3_d   = c3_q;
    c4_d   = c4_q;
    upd_d  = 1'b0;
    if (ld_i) begin
      case (sel)
        3'd0: begin
          n_d    = word_i[N_LSB +: NUM_W];
          frac_d = word_i[LO_FLD +: NUM_W];
          act_d  = stg_q;
          upd_d  = 1'b1;
        end
        3'd1: stg_d.phase = word_i[LO_FLD +: NUM_W];
        3'd2: begin
          stg_d.dbl  = word_i[DBL_B];
          stg_d.half = word_i[HALF_B];
          stg_d.rdiv = word_i[R_LSB +: RDIV_W];
          stg_d.icp  = word_i[ICP_LSB +: ICP_W];
          stg_d.modv = word_i[LO_FLD +: NUM_W];
        end
        3'd3: begin
          c3_d  = word_i[WORD_W-1:SEL_W];
          upd_d = 1'b1;
        end
        3'd4: begin
          c4_d  = word_i[WORD_W-1:SEL_W];
          upd_d = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q  <= '0;
      act_q  <= '0;
      n_q    <= '0;
      frac_q <= '0;
      c3_q   <= '0;
      c4_q   <= '0;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= upd_d;
      if (ld_i) begin
        stg_q  <= stg_d;
        act_q  <= act_d;
        n_q    <= n_d;
        frac_q <= frac_d;
        c3_q   <= c3_d;
        c4_q   <= c4_d;
      end
    end
  end

  assign act_o  = act_q;
  assign n_o    = n_q;
  assign frac_o = frac_q;
  assign cfg3_o = c3_q;
  assign cfg4_o = c4_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_ld_i,
  output logic [NUM_W-1:0]  n_int_o,
  output logic [NUM_W-1:0]  frac_o,
  output logic [NUM_W-1:0]  mod_o,
  output logic [NUM_W-1:0]  phase_o,
  output logic [RDIV_W-1:0] rdiv_o,
  output logic [ICP_W-1:0]  icp_o,
  output logic              dbl_o,
  output logic              half_o,
  output logic [RAW_W-1:0]  cfg3_o,
  output logic [RAW_W-1:0]  cfg4_o,
  output logic              upd_o
);
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] word_w;
  logic              ld_rise_w;
  dbuf_t             act_w;

  cfg_sync #(.W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({ser_ld_i, ser_dat_i, ser_clk_i}),
    .sync_o (pins_s)
  );

  cfg_shift u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sclk_i   (pins_s[0]),
    .sdat_i   (pins_s[1]),
    .sld_i    (pins_s[2]),
    .word_o   (word_w),
    .ld_rise_o(ld_rise_w)
  );

  cfg_bank u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (ld_rise_w),
    .word_i(word_w),
    .act_o (act_w),
    .n_o   (n_int_o),
    .frac_o(frac_o),
    .cfg3_o(cfg3_o),
    .cfg4_o(cfg4_o),
    .upd_o (upd_o)
  );

  assign mod_o   = act_w.modv;
  assign phase_o = act_w.phase;
  assign rdiv_o  = act_w.rdiv;
  assign icp_o   = act_w.icp;
  assign dbl_o   = act_w.dbl;
  assign half_o  = act_w.half;
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk
  import cfg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ld_rise_w,
  input logic [WORD_W-1:0] word_w,
  input logic [NUM_W-1:0]  mod_o,
  input logic [NUM_W-1:0]  phase_o,
  input logic [NUM_W-1:0]  n_int_o,
  input logic              upd_o
);
  // R4: staged fields move only together with an update pulse
  a_r4_mod_only_on_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> (mod_o == $past(mod_o) && phase_o == $past(phase_o)));

  // R3: reserved codes never raise the update pulse
  a_r3_reserved_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_rise_w && word_w[SEL_W-1:0] > 3'd4) |=> !upd_o);

  // R9: update is a single-cycle pulse
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  // R10: every update pulse follows a detected load edge one clock earlier
  a_r10_pulse_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(upd_o) |-> $past(ld_rise_w));

  // R5: a register 0 load always pulses update
  a_r5_commit_pulses: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_rise_w && word_w[SEL_W-1:0] == 3'd0) |=> upd_o);

  // R8: outputs held at zero in reset
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_zero: assert (mod_o == '0 && n_int_o == '0 && !upd_o);
    end
  end
endmodule

bind serial_cfg_loader serial_cfg_loader_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ld_rise_w(ld_rise_w),
  .word_w   (word_w),
  .mod_o    (mod_o),
  .phase_o  (phase_o),
  .n_int_o  (n_int_o),
  .upd_o    (upd_o)
);

// File: tb/sim_serial_cfg_loader.sv
`timescale 1ns/1ps
module sim_serial_cfg_loader;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, sld = 1'b0;
  logic [11:0] n_int, frac, modv, phase;
  logic [4:0]  rdiv;
  logic [3:0]  icp;
  logic        dbl, half, upd;
  logic [28:0] cfg3, cfg4;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  serial_cfg_loader u0 (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_ld_i(sld),
    .n_int_o(n_int), .frac_o(frac), .mod_o(modv), .phase_o(phase), .rdiv_o(rdiv),
    .icp_o(icp), .dbl_o(dbl), .half_o(half), .cfg3_o(cfg3), .cfg4_o(cfg4), .upd_o(upd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit        hc[4], hd[4], hl[4];
  bit [31:0] m_sr;
  bit [11:0] m_n, m_frac, s_mod, s_ph, a_mod, a_ph;
  bit [4:0]  s_r, a_r;
  bit [3:0]  s_i, a_i;
  bit        s_dbl, s_half, a_dbl, a_half, m_upd;
  bit [28:0] m_c3, m_c4;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin hc[i] = 0; hd[i] = 0; hl[i] = 0; end
      m_sr = 0; m_n = 0; m_frac = 0; s_mod = 0; s_ph = 0; a_mod = 0; a_ph = 0;
      s_r = 0; a_r = 0; s_i = 0; a_i = 0; s_dbl = 0; s_half = 0; a_dbl = 0; a_half = 0;
      m_c3 = 0; m_c4 = 0; m_upd = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin hc[i] = hc[i-1]; hd[i] = hd[i-1]; hl[i] = hl[i-1]; end
      hc[0] = sclk; hd[0] = sdat; hl[0] = sld;
      m_upd = 0;
      if (hl[2] && !hl[3]) begin
        case (m_sr[2:0])
          3'd0: begin
            m_n = m_sr[26:15]; m_frac = m_sr[14:3];
            a_mod = s_mod; a_ph = s_ph; a_r = s_r; a_i = s_i; a_dbl = s_dbl; a_half = s_half;
            m_upd = 1;
          end
          3'd1: s_ph = m_sr[14:3];
          3'd2: begin
            s_dbl = m_sr[25]; s_half = m_sr[24]; s_r = m_sr[23:19];
            s_i = m_sr[18:15]; s_mod = m_sr[14:3];
          end
          3'd3: begin m_c3 = m_sr[31:3]; m_upd = 1; end
          3'd4: begin m_c4 = m_sr[31:3]; m_upd = 1; end
          default: ;
        endcase
      end
      if (hc[2] && !hc[3]) m_sr = {m_sr[30:0], hd[2]};
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R5 n_int", {20'd0, n_int}, {20'd0, m_n});
      chk("R5 frac", {20'd0, frac}, {20'd0, m_frac});
      chk("R4 mod", {20'd0, modv}, {20'd0, a_mod});
      chk("R4 phase", {20'd0, phase}, {20'd0, a_ph});
      chk("R4 ctl", {20'd0, a_dbl, a_half, a_r, a_i}, {20'd0, dbl, half, rdiv, icp});
      chk("R7 cfg3", {3'd0, cfg3}, {3'd0, m_c3});
      chk("R7 cfg4", {3'd0, cfg4}, {3'd0, m_c4});
      chk("R9 upd", {31'd0, upd}, {31'd0, m_upd});
    end
  end

  // sends a word and returns the number of negedges until upd_o (0 = none)
  task automatic send(input logic [31:0] w, output int lat);
    lat = 0;
    for (int b = 31; b >= 0; b--) begin
      sdat = w[b];
      repeat (3) @(negedge clk);
      sclk = 1'b1;
      repeat (3) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (2) @(negedge clk);
    sld = 1'b1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (upd && lat == 0) lat = i;
    end
    sld = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] mk_r0(input logic [11:0] n, input logic [11:0] f);
    return {5'd0, n, f, 3'd0};
  endfunction

  function automatic logic [31:0] mk_r2(input logic d, input logic h, input logic [4:0] r,
                                        input logic [3:0] c, input logic [11:0] m);
    return {6'd0, d, h, r, c, m, 3'd2};
  endfunction

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    chk("R8 reset mod", {20'd0, modv}, 32'd0);
    chk("R8 reset cfg3", {3'd0, cfg3}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    send(mk_r2(1'b1, 1'b0, 5'd19, 4'hA, 12'hABC), lat);
    chk("R4 staging silent", lat, 0);
    chk("R4 mod still zero", {20'd0, modv}, 32'd0);
    send({17'd0, 12'h5A5, 3'd1}, lat);
    chk("R4 phase staged silent", {20'd0, phase}, 32'd0);
    send(mk_r0(12'h123, 12'hFED), lat);
    chk("R10 latency", lat, 3);
    chk("R1 msb first n", {20'd0, n_int}, 32'h123);
    chk("R6 mod field", {20'd0, modv}, 32'hABC);
    chk("R6 rdiv field", {27'd0, rdiv}, 32'd19);
    chk("R6 icp/dbl/half", {26'd0, dbl, half, icp}, {26'd0, 1'b1, 1'b0, 4'hA});
    chk("R6 phase field", {20'd0, phase}, 32'h5A5);

    send({29'h1ABCDEF1, 3'd3}, lat);
    chk("R2 code 3 dest", {3'd0, cfg3}, 32'h1ABCDEF1);
    chk("R10 latency r3", lat, 3);
    send({29'h0F0F0F0F, 3'd4}, lat);
    chk("R2 code 4 dest", {3'd0, cfg4}, 32'h0F0F0F0F);

    for (int c = 5; c < 8; c++) begin
      send({29'h1FFFFFFF, c[2:0]}, lat);
      chk("R3 reserved no pulse", lat, 0);
      chk("R3 cfg4 kept", {3'd0, cfg4}, 32'h0F0F0F0F);
      chk("R3 n kept", {20'd0, n_int}, 32'h123);
    end

    send(mk_r2(1'b0, 1'b1, 5'd3, 4'h5, 12'h00F), lat);
    chk("R4 second stage hidden", {20'd0, modv}, 32'hABC);
    send(mk_r0(12'hFFF, 12'h001), lat);
    chk("R5 commit modulus", {20'd0, modv}, 32'h00F);
    chk("R5 commit half", {31'd0, half}, 32'd1);
    chk("R5 frac", {20'd0, frac}, 32'h001);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule